// File: doc/BRIEF.md
# Scaled FP8 to BFloat16 Vector Converter

This block widens a packed vector of 8-bit floating-point values into BFloat16. Only the upper byte of each 16-bit pair is used. The result for that byte fills the whole 16-bit lane that holds the pair. Each value is multiplied by a power of two, 2^-N, as it is converted. N is an unsigned 6-bit field. Every lane is written on every cycle. There is no lane masking.

Two control sets exist. Each set has one format bit and one scale field. A single variant bit picks which set is active for the whole vector. The format bit chooses how the source bytes are read: either with a 4-bit exponent and 3-bit fraction, or with a 5-bit exponent and 2-bit fraction. The conversion path is combinational. An optional output register, on by default, gives a one-cycle latency.

Every finite input, after any scale from 0 to 63, lands inside the normal BFloat16 range. The fraction always fits in 7 bits. For this reason every finite result is exact.

Top module: `fp8_bf16_cvt`

## Requirements
- R1: Output lane e (bits 16e+15..16e) depends only on source byte 2e+1 (bits 16e+15..16e+8) and the active controls. The even byte in bits 16e+7..16e has no effect.
- R2: With `var_sel`=0 the lane uses `fmt_sel1` and `scale1`. With `var_sel`=1 it uses `fmt_sel2` and `scale2`. The fields of the inactive set have no effect.
- R3: Format bit 0 reads the byte as sign bit 7, exponent bits 6..3 (bias 7) and fraction bits 2..0. This format has no infinity. Magnitude code 0x7F is NaN, and exponent 15 with fraction below 7 is an ordinary finite value.
- R4: Format bit 1 reads the byte as sign bit 7, exponent bits 6..2 (bias 15) and fraction bits 1..0. Magnitude 0x7C gives a signed infinity (0x7F80 or 0xFF80), whatever the scale.
- R5: Every NaN source gives 0x7FC0, whatever its sign or the scale. The NaN sources are magnitude 0x7F with format 0, and exponent 31 with a nonzero fraction under format 1.
- R6: A finite nonzero source of value v gives the exact BFloat16 encoding of v·2^-N. The sign is kept, the exponent is biased by 127, and N is the active 6-bit scale (0..63).
- R7: Subnormal sources (exponent field 0, nonzero fraction) are normalized. They convert exactly under R6.
- R8: A zero source gives a zero with the same sign (0x0000 or 0x8000) for any scale.
- R9: While `rst_n` is low at a rising edge, `res_vec` is cleared to zero. Otherwise each result appears on `res_vec` one rising edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| var_sel | input | 1 | Selects control set 1 (0) or set 2 (1) |
| fmt_sel1 | input | 1 | Source format for set 1: 0 = 4-bit exponent, 1 = 5-bit exponent |
| fmt_sel2 | input | 1 | Source format for set 2 |
| scale1 | input | 6 | Downscale exponent N for set 1 |
| scale2 | input | 6 | Downscale exponent N for set 2 |
| src_vec | input | 16·LANES | Packed source bytes; odd bytes converted |
| res_vec | output | 16·LANES | Packed BFloat16 results, one per lane |

## Verification
Each result is due exactly one rising edge after its inputs are applied. The bench applies a new vector on every falling edge. At the same moment it queues the expected lanes, computed from a real-number model of the two byte formats and the scale. On the next falling edge it takes that entry from the queue and compares it with `res_vec`. The pattern covers all 256 codes in both formats, at several scales, under both variants. The even bytes and the inactive control fields are filled with unrelated values. A clear of the output during reset is checked before the first vector.

// File: rtl/fp8bf_pkg.sv
// Package: shared types and constants for the FP8 to BFloat16 converter.
// Assumes: scale fields of at most 6 bits, so every finite result stays normal.
package fp8bf_pkg;

    // Class of a decoded source byte
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_FIN  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp8_cls_e;

    // Decoded source: unbiased exponent and 3 fraction bits after normalization
    typedef struct packed {
        logic              sign;
        fp8_cls_e          cls;
        logic signed [6:0] exp_unb;
        logic [2:0]        frac;
    } fp8_unpk_t;

    localparam logic [7:0]  BF_BIAS    = 8'd127;
    localparam logic [15:0] BF_QNAN    = 16'h7FC0;
    localparam logic [14:0] BF_INF_MAG = 15'h7F80;

endpackage

// File: rtl/fp8_ctrl_sel.sv
// Module: picks the active format bit and scale field from two control sets.
// Assumes: the variant bit is valid for the whole vector in the same cycle.
module fp8_ctrl_sel #(
    parameter int SCALE_W = 6
) (
    input  logic               var_sel,
    input  logic               fmt_a,
    input  logic               fmt_b,
    input  logic [SCALE_W-1:0] scale_a,
    input  logic [SCALE_W-1:0] scale_b,
    output logic               fmt_o,
    output logic [SCALE_W-1:0] scale_o
);

    // Route set 1 when the variant bit is low, set 2 when it is high
    always_comb begin
        if (var_sel) begin
            fmt_o   = fmt_b;
            scale_o = scale_b;
        end else begin
            fmt_o   = fmt_a;
            scale_o = scale_a;
        end
    end

endmodule

// File: rtl/fp8_unpack.sv
// Module: decodes one 8-bit float into sign, class, unbiased exponent and a
// 3-bit fraction. Subnormals are normalized here.
// Assumes: fmt_i = 0 is the 4-bit exponent form, 1 is the 5-bit exponent form.
module fp8_unpack
    import fp8bf_pkg::*;
(
    input  logic      [7:0] byte_i,
    input  logic            fmt_i,
    output fp8_unpk_t       unpk_o
);

    logic [3:0] e4;
    logic [2:0] m3;
    logic [4:0] e5;
    logic [1:0] m2;

    // Split the byte into fields for both layouts
    always_comb begin
        e4 = byte_i[6:3];
        m3 = byte_i[2:0];
        e5 = byte_i[6:2];
        m2 = byte_i[1:0];
    end

    // Classify and normalize according to the selected layout
    always_comb begin
        unpk_o.sign    = byte_i[7];
        unpk_o.cls     = CLS_FIN;
        unpk_o.exp_unb = '0;
        unpk_o.frac    = '0;
        if (!fmt_i) begin
            if (e4 == 4'hF && m3 == 3'h7) begin
                unpk_o.cls = CLS_NAN;
            end else if (e4 == 4'h0 && m3 == 3'h0) begin
                unpk_o.cls = CLS_ZERO;
            end else if (e4 == 4'h0) begin
                casez (m3)
                    3'b1??: begin
                        unpk_o.exp_unb = -7'sd7;
                        unpk_o.frac    = {m3[1:0], 1'b0};
                    end
                    3'b01?: begin
                        unpk_o.exp_unb = -7'sd8;
                        unpk_o.frac    = {m3[0], 2'b00};
                    end
                    default: begin
                        unpk_o.exp_unb = -7'sd9;
                        unpk_o.frac    = 3'b000;
                    end
                endcase
            end else begin
                unpk_o.exp_unb = $signed({3'b000, e4}) - 7'sd7;
                unpk_o.frac    = m3;
            end
        end else begin
            if (e5 == 5'h1F) begin
                unpk_o.cls = (m2 == 2'b00) ? CLS_INF : CLS_NAN;
            end else if (e5 == 5'h00 && m2 == 2'b00) begin
                unpk_o.cls = CLS_ZERO;
            end else if (e5 == 5'h00) begin
                if (m2[1]) begin
                    unpk_o.exp_unb = -7'sd15;
                    unpk_o.frac    = {m2[0], 2'b00};
                end else begin
                    unpk_o.exp_unb = -7'sd16;
                    unpk_o.frac    = 3'b000;
                end
            end else begin
                unpk_o.exp_unb = $signed({2'b00, e5}) - 7'sd15;
                unpk_o.frac    = {m2, 1'b0};
            end
        end
    end

endmodule

// File: rtl/fp8_bf16_pack.sv
// Module: applies the 2^-N downscale to a decoded value and builds BFloat16.
// Assumes: exponent -16..15 and N <= 63, so the biased result is 48..142.
// Modular 8-bit arithmetic is therefore exact, and no rounding is needed.
module fp8_bf16_pack
    import fp8bf_pkg::*;
#(
    parameter int SCALE_W = 6
) (
    input  fp8_unpk_t          unpk_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [15:0]        bf_o
);

    logic [7:0] exp_biased;

    // Rebias into the 8-bit exponent and subtract the scale
    always_comb begin
        exp_biased = {unpk_i.exp_unb[6], unpk_i.exp_unb} + BF_BIAS
                     - 8'(scale_i);
    end

    // Assemble the output word per class
    always_comb begin
        unique case (unpk_i.cls)
            CLS_ZERO: bf_o = {unpk_i.sign, 15'd0};
            CLS_INF:  bf_o = {unpk_i.sign, BF_INF_MAG};
            CLS_NAN:  bf_o = BF_QNAN;
            default:  bf_o = {unpk_i.sign, exp_biased, unpk_i.frac, 4'b0000};
        endcase
    end

endmodule

// File: rtl/fp8_bf16_cvt.sv
// Module: vector converter. Each 16-bit lane takes its upper byte, decodes it
// in the active format, downscales it and writes BFloat16 into the lane.
// Assumes: PIPE = 1 adds one output register (synchronous active-low reset).
// PIPE = 0 leaves the path combinational.
module fp8_bf16_cvt
    import fp8bf_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int SCALE_W = 6,
    parameter bit PIPE    = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  var_sel,
    input  logic                  fmt_sel1,
    input  logic                  fmt_sel2,
    input  logic [SCALE_W-1:0]    scale1,
    input  logic [SCALE_W-1:0]    scale2,
    input  logic [LANES*16-1:0]   src_vec,
    output logic [LANES*16-1:0]   res_vec
);

    localparam int LANE_W = 16;
    localparam int VEC_W  = LANES * LANE_W;

    logic               act_fmt;
    logic [SCALE_W-1:0] act_scale;
    logic [VEC_W-1:0]   comb_vec;
    logic [15:0]        lane_bf [LANES];

    fp8_ctrl_sel #(.SCALE_W(SCALE_W)) u_sel (
        .var_sel (var_sel),
        .fmt_a   (fmt_sel1),
        .fmt_b   (fmt_sel2),
        .scale_a (scale1),
        .scale_b (scale2),
        .fmt_o   (act_fmt),
        .scale_o (act_scale)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fp8_unpk_t  unpk;
        logic [7:0] src_b;

        assign src_b = src_vec[g*LANE_W + 8 +: 8];

        fp8_unpack u_unpack (
            .byte_i (src_b),
            .fmt_i  (act_fmt),
            .unpk_o (unpk)
        );

        fp8_bf16_pack #(.SCALE_W(SCALE_W)) u_pack (
            .unpk_i  (unpk),
            .scale_i (act_scale),
            .bf_o    (lane_bf[g])
        );

        assign comb_vec[g*LANE_W +: LANE_W] = lane_bf[g];

        // Port-level view of the active format, used only by the checks below
        logic fmt_p;
        logic is_nan_p;
        logic is_inf_p;
        assign fmt_p    = var_sel ? fmt_sel2 : fmt_sel1;
        assign is_nan_p = fmt_p ? (src_b[6:2] == 5'h1F && src_b[1:0] != 2'b00)
                                : (src_b[6:0] == 7'h7F);
        assign is_inf_p = fmt_p && (src_b[6:0] == 7'h7C);

        p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
            is_nan_p |-> lane_bf[g] == 16'h7FC0);

        p_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
            is_inf_p |-> lane_bf[g] == {src_b[7], 15'h7F80});

        p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (src_b[6:0] == 7'h00) |-> lane_bf[g] == {src_b[7], 15'd0});

        p_finite_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_nan_p && !is_inf_p && src_b[6:0] != 7'h00)
            |-> (lane_bf[g][15] == src_b[7]
                 && lane_bf[g][14:7] >= 8'd48 && lane_bf[g][14:7] <= 8'd142));
    end

    if (PIPE) begin : g_pipe
        // Register the converted vector; clear it during reset
        always_ff @(posedge clk) begin
            if (!rst_n) res_vec <= '0;
            else        res_vec <= comb_vec;
        end

        p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> res_vec == '0);
    end else begin : g_comb
        assign res_vec = comb_vec;
    end

endmodule

// File: tb/tb_fp8_bf16_cvt.sv
// Bench: drives a vector every falling edge and queues the expected lanes
// from a real-number model. Compares one cycle later.
module tb_fp8_bf16_cvt;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int VEC_W      = LANES * 16;
    localparam int LAT        = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             var_sel = 1'b0;
    logic             fmt_sel1 = 1'b0;
    logic             fmt_sel2 = 1'b0;
    logic [5:0]       scale1 = '0;
    logic [5:0]       scale2 = '0;
    logic [VEC_W-1:0] src_vec = '0;
    logic [VEC_W-1:0] res_vec;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [VEC_W-1:0] q_src [$];
    bit               q_fmt [$];
    int               q_sc  [$];
    bit               q_var [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp8_bf16_cvt #(.LANES(LANES), .SCALE_W(6), .PIPE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .var_sel(var_sel),
        .fmt_sel1(fmt_sel1), .fmt_sel2(fmt_sel2),
        .scale1(scale1), .scale2(scale2),
        .src_vec(src_vec), .res_vec(res_vec)
    );

    function automatic real pow2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    // Reference: decode the byte as a real, scale, encode as BFloat16
    function automatic logic [15:0] ref_bf(input logic [7:0] b, input bit f,
                                           input int sc);
        real v;
        int  ex;
        int  fr;
        if (!f) begin
            if (b[6:0] == 7'h7F) return 16'h7FC0;
            if (b[6:3] == 0) v = real'(b[2:0]) * pow2(-9);
            else v = (1.0 + real'(b[2:0]) / 8.0) * pow2(int'(b[6:3]) - 7);
        end else begin
            if (b[6:2] == 5'h1F)
                return (b[1:0] == 0) ? {b[7], 15'h7F80} : 16'h7FC0;
            if (b[6:2] == 0) v = real'(b[1:0]) * pow2(-16);
            else v = (1.0 + real'(b[1:0]) / 4.0) * pow2(int'(b[6:2]) - 15);
        end
        v = v * pow2(-sc);
        if (v == 0.0) return {b[7], 15'd0};
        ex = 0;
        while (v >= 2.0) begin v = v / 2.0; ex++; end
        while (v < 1.0)  begin v = v * 2.0; ex--; end
        fr = int'((v - 1.0) * 128.0);
        return {b[7], 8'(ex + 127), 7'(fr)};
    endfunction

    // Requirement tag for a source byte
    function automatic string tag_of(input logic [7:0] b, input bit f);
        if ((!f && b[6:0] == 7'h7F) || (f && b[6:2] == 5'h1F && b[1:0] != 0))
            return "R5";
        if (b[6:0] == 0) return "R8";
        if (!f && b[6:3] == 0) return "R7";
        if (f && b[6:2] == 0)  return "R7";
        return f ? "R4" : "R3";
    endfunction

    // Compare the oldest queued vector with the output (R1 R2 R6)
    task automatic check_front();
        logic [VEC_W-1:0] s;
        bit f;
        int sc;
        bit v;
        s  = q_src.pop_front();
        f  = q_fmt.pop_front();
        sc = q_sc.pop_front();
        v  = q_var.pop_front();
        for (int l = 0; l < LANES; l++) begin
            logic [7:0]  b;
            logic [15:0] exp_v;
            b = s[l*16 + 8 +: 8];
            exp_v = ref_bf(b, f, sc);
            checks++;
            if (res_vec[l*16 +: 16] !== exp_v) begin
                errors++;
                $display("FAIL %s R1 R2 R6 var=%0d fmt=%0d sc=%0d byte=%h lane=%0d actual=%h expected=%h",
                         tag_of(b, f), v, f, sc, b, l, res_vec[l*16 +: 16], exp_v);
            end
        end
    endtask

    // Apply one vector; the inactive set gets unrelated values (R2)
    task automatic drive(input bit v, input bit f, input int sc, input int base);
        @(negedge clk);
        if (q_src.size() >= LAT) check_front();
        var_sel = v;
        if (!v) begin
            fmt_sel1 = f;  scale1 = 6'(sc);
            fmt_sel2 = ~f; scale2 = 6'(63 - sc);
        end else begin
            fmt_sel2 = f;  scale2 = 6'(sc);
            fmt_sel1 = ~f; scale1 = 6'(63 - sc);
        end
        for (int l = 0; l < LANES; l++) begin
            src_vec[l*16 + 8 +: 8] = 8'(base + l);
            src_vec[l*16 +: 8]     = 8'($urandom);   // even byte is noise (R1)
        end
        q_src.push_back(src_vec);
        q_fmt.push_back(f);
        q_sc.push_back(sc);
        q_var.push_back(v);
    endtask

    initial begin
        int scales[5] = '{0, 1, 7, 20, 63};
        src_vec = {LANES{16'hA55A}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_vec !== '0) begin   // R9 reset clear
            errors++;
            $display("FAIL R9 reset actual=%h expected=0", res_vec);
        end
        rst_n = 1'b1;
        for (int v = 0; v < 2; v++)
            for (int f = 0; f < 2; f++)
                for (int si = 0; si < 5; si++)
                    for (int base = 0; base < 256; base += LANES)
                        drive(v[0], f[0], scales[si], base);
        @(negedge clk);
        if (q_src.size() >= LAT) check_front();   // R9 one-cycle latency
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule